// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Access Control

This block is the clock-synchronous front end of a small common-I/O SRAM, together with its storage. On each rising edge it samples an address, two address strobes (a processor strobe and a controller strobe), three chip enables, a global write, a byte write enable and one byte select per lane. From these it decodes single read and write accesses, writes the selected 9-bit lanes of a 36-bit word, and returns read data through an output register. It also produces the three-state enable for the shared data bus.

The two strobes have different write timing. A controller-strobe write commits on the edge that samples it. A processor-strobe access only captures the address on its first edge. If write controls are present on the next edge, it commits the write there, using the data sampled at that edge. Read data is registered one edge after the access starts. The bus enable is cleared by a write or a deselect, and it never rises in the first cycle of an access. The output-enable pin gates the bus enable without a clock.

Top module: `sram_pipe_ctrl`

## Requirements
- R1: A controller-strobe access with the processor strobe high, all chip enables active and global write low writes `wdata_i` to `addr_i` on that same edge.
- R2: With global write high and byte write enable low, only lanes whose `bsel_ni` bit is low are written, where lane l is bits [9l+8:9l]. The other lanes keep their contents.
- R3: Global write low writes all four lanes, whatever the values of byte write enable and the byte selects.
- R4: A processor-strobe access ignores the write controls sampled on its first edge. When the next edge has no valid strobe and a write combination, that edge writes `wdata_i` to the captured address, with the lane mask sampled at that edge.
- R5: The processor strobe has no effect while chip enable 1 (`ce1_ni`) is high. No access starts, no write occurs and the bus enable keeps its state.
- R6: A read (strobe valid, chip enables active, global write and byte write enable both high) puts the word on `rdata_o` after the next rising edge. There `dq_oe_o` goes high when `oe_ni` is low. In the first cycle of a read that follows a deselect, `dq_oe_o` stays low.
- R7: `dq_oe_o` is low whenever `oe_ni` is high, with no clock edge needed.
- R8: After an edge that commits a write, `dq_oe_o` is low, even if `oe_ni` is low.
- R9: After an edge at which a valid strobe is sampled while the chip enables are not all active, `dq_oe_o` is low.
- R10: During and right after reset, `dq_oe_o` is low and `rdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Word address |
| proc_strb_ni | input | 1 | Processor address strobe, active low |
| ctrl_strb_ni | input | 1 | Controller address strobe, active low |
| ce1_ni | input | 1 | Chip enable 1, active low; also gates the processor strobe |
| ce2_i | input | 1 | Chip enable 2, active high |
| ce3_ni | input | 1 | Chip enable 3, active low |
| gw_ni | input | 1 | Global write, active low |
| bwe_ni | input | 1 | Byte write enable, active low |
| bsel_ni | input | 4 | Byte lane selects, active low |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| wdata_i | input | 36 | Write data |
| rdata_o | output | 36 | Registered read data |
| dq_oe_o | output | 1 | Data bus drive enable, active high |

## Verification
The hardest case to reach is the second edge of a processor-strobe write. The first edge must carry write controls that are to be ignored. The next edge must carry a different lane mask and fresh data, and it must have no strobe. The bench drives both edges from one task, using a global write on the first edge and a single-lane byte write on the second, and then reads the word back to see that only that lane changed. A second hard case is a processor strobe blocked by chip enable 1 while the bus is driving. Here the bench checks that the bus enable holds across that edge and across the following write-looking edge, and that the array word is unchanged.

// File: rtl/sram_pipe_pkg.sv
package sram_pipe_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned LANE_W = 9;
  localparam int unsigned WORD_W = LANES * LANE_W;

  typedef logic [LANES-1:0]  lane_mask_t;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/sram_cmd_decode.sv
module sram_cmd_decode
  import sram_pipe_pkg::*;
(
  input  logic       proc_strb_ni,
  input  logic       ctrl_strb_ni,
  input  logic       ce1_ni,
  input  logic       ce2_i,
  input  logic       ce3_ni,
  input  logic       gw_ni,
  input  logic       bwe_ni,
  input  lane_mask_t bsel_ni,
  input  logic       acc_q_i,
  output logic       proc_start_o,
  output logic       ctrl_rd_o,
  output logic       ctrl_wr_o,
  output logic       pend_wr_o,
  output logic       desel_o,
  output lane_mask_t wmask_o
);
  logic sel, proc_v, ctrl_v, any_v, wr_ctl;

  assign sel    = !ce1_ni && ce2_i && !ce3_ni;
  // processor strobe is gated by chip enable 1 and wins over the controller strobe
  assign proc_v = !proc_strb_ni && !ce1_ni;
  assign ctrl_v = !ctrl_strb_ni && !proc_v;
  assign any_v  = proc_v || ctrl_v;
  assign wr_ctl = !gw_ni || !bwe_ni;

  assign proc_start_o = proc_v && sel;
  assign ctrl_wr_o    = ctrl_v && sel && wr_ctl;
  assign ctrl_rd_o    = ctrl_v && sel && !wr_ctl;
  assign pend_wr_o    = acc_q_i && !any_v && wr_ctl;
  assign desel_o      = any_v && !sel;
  assign wmask_o      = !gw_ni ? '1 : (bwe_ni ? '0 : ~bsel_ni);
endmodule

// File: rtl/sram_byte_array.sv
module sram_byte_array
  import sram_pipe_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  lane_mask_t    mask_i,
  input  logic [AW-1:0] waddr_i,
  input  word_t         wdata_i,
  input  logic [AW-1:0] raddr_i,
  output word_t         rdata_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && mask_i[l]) lane_mem[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end

    assign rdata_o[l*LANE_W +: LANE_W] = lane_mem[raddr_i];
  end
endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage
  import sram_pipe_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  desel_i,
  input  logic  wr_commit_i,
  input  logic  rd_pend_i,
  input  word_t mem_rdata_i,
  input  logic  oe_ni,
  output word_t rdata_o,
  output logic  dq_oe_o
);
  logic en_q;
  word_t data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      data_q <= '0;
    end else if (desel_i || wr_commit_i) begin
      en_q <= 1'b0;
    end else if (rd_pend_i) begin
      en_q   <= 1'b1;
      data_q <= mem_rdata_i;
    end
  end

  assign rdata_o = data_q;
  assign dq_oe_o = en_q && !oe_ni;

  a_r9_desel_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desel_i |=> !en_q);
  a_r8_write_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_commit_i |=> !en_q);
  a_r6_read_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_pend_i && !desel_i && !wr_commit_i) |=> en_q);
  a_r6_data_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_pend_i |=> $stable(data_q));
endmodule

// File: rtl/sram_pipe_ctrl.sv
module sram_pipe_ctrl
  import sram_pipe_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [AW-1:0]          addr_i,
  input  logic                   proc_strb_ni,
  input  logic                   ctrl_strb_ni,
  input  logic                   ce1_ni,
  input  logic                   ce2_i,
  input  logic                   ce3_ni,
  input  logic                   gw_ni,
  input  logic                   bwe_ni,
  input  logic [LANES-1:0]       bsel_ni,
  input  logic                   oe_ni,
  input  logic [WORD_W-1:0]      wdata_i,
  output logic [WORD_W-1:0]      rdata_o,
  output logic                   dq_oe_o
);
  logic          proc_start, ctrl_rd, ctrl_wr, pend_wr, desel;
  lane_mask_t    wmask;
  logic [AW-1:0] addr_q, waddr;
  logic          acc_q, rd_q, wr_commit;
  word_t         mem_rdata;

  sram_cmd_decode u_dec (
    .proc_strb_ni (proc_strb_ni),
    .ctrl_strb_ni (ctrl_strb_ni),
    .ce1_ni       (ce1_ni),
    .ce2_i        (ce2_i),
    .ce3_ni       (ce3_ni),
    .gw_ni        (gw_ni),
    .bwe_ni       (bwe_ni),
    .bsel_ni      (bsel_ni),
    .acc_q_i      (acc_q),
    .proc_start_o (proc_start),
    .ctrl_rd_o    (ctrl_rd),
    .ctrl_wr_o    (ctrl_wr),
    .pend_wr_o    (pend_wr),
    .desel_o      (desel),
    .wmask_o      (wmask)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      acc_q  <= 1'b0;
      rd_q   <= 1'b0;
    end else begin
      if (proc_start || ctrl_rd) addr_q <= addr_i;
      acc_q <= proc_start;
      rd_q  <= proc_start || ctrl_rd;
    end
  end

  assign wr_commit = ctrl_wr || pend_wr;
  // controller write uses the live address, processor write the captured one
  assign waddr     = ctrl_wr ? addr_i : addr_q;

  sram_byte_array #(.DEPTH(DEPTH)) u_mem (
    .clk_i   (clk_i),
    .we_i    (wr_commit),
    .mask_i  (wmask),
    .waddr_i (waddr),
    .wdata_i (wdata_i),
    .raddr_i (addr_q),
    .rdata_o (mem_rdata)
  );

  sram_out_stage u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .desel_i     (desel),
    .wr_commit_i (wr_commit),
    .rd_pend_i   (rd_q),
    .mem_rdata_i (mem_rdata),
    .oe_ni       (oe_ni),
    .rdata_o     (rdata_o),
    .dq_oe_o     (dq_oe_o)
  );

  a_r5_ce1_gates_proc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q |-> $past(!proc_strb_ni && !ce1_ni));
  a_r4_pend_one_shot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q |=> !acc_q || $past(!proc_strb_ni));
endmodule

// File: tb/sram_pipe_ctrl_tb.sv
module sram_pipe_ctrl_tb;
  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          proc_n, ctrl_n, ce1_n, ce2, ce3_n, gw_n, bwe_n, oe_n;
  logic [3:0]    bsel_n;
  logic [35:0]   wdata, rdata;
  logic          dq_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [35:0] model [DEPTH];

  always #10 clk = ~clk;

  sram_pipe_ctrl #(.DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .proc_strb_ni(proc_n),
    .ctrl_strb_ni(ctrl_n), .ce1_ni(ce1_n), .ce2_i(ce2), .ce3_ni(ce3_n),
    .gw_ni(gw_n), .bwe_ni(bwe_n), .bsel_ni(bsel_n), .oe_ni(oe_n),
    .wdata_i(wdata), .rdata_o(rdata), .dq_oe_o(dq_oe)
  );

  task automatic chk(string tag, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    proc_n = 1; ctrl_n = 1; ce1_n = 0; ce2 = 1; ce3_n = 0;
    gw_n = 1; bwe_n = 1; bsel_n = 4'hF; wdata = '0;
  endtask

  function automatic logic [35:0] merge(logic [35:0] old, logic [35:0] nw, logic [3:0] m);
    logic [35:0] r = old;
    for (int l = 0; l < 4; l++) if (m[l]) r[l*9 +: 9] = nw[l*9 +: 9];
    return r;
  endfunction

  task automatic ctrl_write(logic [AW-1:0] a, logic [35:0] d, logic g, logic b,
                            logic [3:0] s, string tag);
    logic [3:0] m = !g ? 4'hF : (b ? 4'h0 : ~s);
    ctrl_n = 0; addr = a; wdata = d; gw_n = g; bwe_n = b; bsel_n = s;
    @(negedge clk); idle();
    model[a] = merge(model[a], d, m);
    chk({tag, " R8 hiz after write"}, dq_oe, 1'b0);
  endtask

  task automatic read_check(logic [AW-1:0] a, bit use_proc, bit first_hiz, string tag);
    if (use_proc) proc_n = 0; else ctrl_n = 0;
    addr = a;
    @(negedge clk); idle();
    if (first_hiz) chk({tag, " R6 first cycle hiz"}, dq_oe, 1'b0);
    @(negedge clk);
    chk({tag, " R6 read data"}, rdata, model[a]);
    chk({tag, " R6 bus driven"}, dq_oe, 1'b1);
  endtask

  task automatic t_reset();
    chk("R10 reset dq_oe", dq_oe, 1'b0);
    chk("R10 reset rdata", rdata, '0);
  endtask

  task automatic t_ctrl_full();
    ctrl_write(4'd3, 36'h1_2345_6789, 1'b0, 1'b1, 4'hF, "R1");
    read_check(4'd3, 1'b0, 1'b1, "R1");
  endtask

  task automatic t_byte_lanes();
    ctrl_write(4'd3, 36'hA_BCDE_F012, 1'b1, 1'b0, 4'b1010, "R2");
    read_check(4'd3, 1'b0, 1'b0, "R2");
    chk("R2 lane1 kept", {27'd0, rdata[17:9]}, {27'd0, 9'h0B3});
  endtask

  task automatic t_gw_override();
    ctrl_write(4'd5, 36'hF_0F0F_0F0F, 1'b0, 1'b1, 4'hF, "R3");
    read_check(4'd5, 1'b0, 1'b0, "R3");
  endtask

  task automatic t_proc_write();
    proc_n = 0; addr = 4'd5; gw_n = 0; wdata = 36'h0_0000_0000;
    @(negedge clk); idle();
    bwe_n = 0; bsel_n = 4'b1101; wdata = 36'h5_5555_5555;
    @(negedge clk); idle();
    model[5] = merge(model[5], 36'h5_5555_5555, 4'b0010);
    chk("R4 hiz after second edge write", dq_oe, 1'b0);
    read_check(4'd5, 1'b1, 1'b1, "R4");
  endtask

  task automatic t_ce1_gate();
    proc_n = 0; ce1_n = 1; addr = 4'd5; gw_n = 0; wdata = 36'h0_DEAD_BEEF;
    @(negedge clk); idle();
    chk("R5 bus held after blocked strobe", dq_oe, 1'b1);
    bwe_n = 0; bsel_n = 4'h0; wdata = 36'h0_DEAD_BEEF;
    @(negedge clk); idle();
    chk("R5 no pending write", dq_oe, 1'b1);
    read_check(4'd5, 1'b0, 1'b0, "R5");
  endtask

  task automatic t_oe_async();
    oe_n = 1; #1;
    chk("R7 oe high forces hiz", dq_oe, 1'b0);
    oe_n = 0; #1;
    chk("R7 oe low restores", dq_oe, 1'b1);
  endtask

  task automatic t_deselect();
    ctrl_n = 0; ce2 = 0; addr = 4'd3;
    @(negedge clk); idle();
    chk("R9 deselect hiz", dq_oe, 1'b0);
    read_check(4'd3, 1'b0, 1'b1, "R9");
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    idle(); oe_n = 0; addr = '0; rst_n = 0;
    @(negedge clk); @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    // seed addresses used later so the model matches
    ctrl_write(4'd5, '0, 1'b0, 1'b1, 4'hF, "R1 seed");
    t_ctrl_full();
    t_byte_lanes();
    t_gw_override();
    t_proc_write();
    t_ce1_gate();
    t_oe_async();
    t_deselect();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule